// File: doc/BRIEF.md
# Fail-Safe Motor Run Interlock

This block decides, once per scan, whether a motor may run. An operator gives a momentary start request. Three safety permissives qualify that request: emergency stop, thermal overload and guard door. Each permissive is fail-safe: it is high while healthy and low when pressed, tripped, opened or disconnected. The block keeps the run state in its own register. The start request is sealed in by the run output itself. The permissives stay in series with both the start request and that seal, so any trip drops the motor. A permissive that recovers never restarts the motor; only a fresh start request does.

The state advances only on clock edges that carry a scan pulse. Between scans the output holds its value. A first-scan input clears the run state at start-up, and an active-low asynchronous reset does the same. A separate combinational output reports the AND of the three permissives, so the interlock chain can be observed apart from the latch.

Top module: `motor_run_ilk`

## Requirements
- R1: `permit_ok` is 1 exactly when `estop_ok`, `ovld_ok` and `door_ok` are all 1 (1 = healthy, 0 = tripped), with no clock delay.
- R2: On a scan edge (`scan_en`=1) with any permissive at 0, `run` is 0 after that edge, whatever it held before.
- R3: On a scan edge with all permissives at 1 and `start_req`=1, `run` is 1 after that edge.
- R4: On a scan edge with `run`=1, all permissives at 1 and `start_req`=0, `run` stays 1 (self-hold).
- R5: On a scan edge with `run`=0 and `start_req`=0, `run` stays 0, even if the permissives have just recovered.
- R6: When `start_req`=1 and a permissive is 0 on the same scan edge, `run` is 0 (stop dominates).
- R7: On a clock edge with `scan_en`=0 and `first_scan`=0, `run` keeps its value whatever the other inputs do.
- R8: `first_scan`=1 on any clock edge clears `run` to 0 after that edge, overriding `scan_en`, `start_req` and the permissives.
- R9: While `rst_n` is 0, `run` is 0 without waiting for a clock; release of `rst_n` reaches the run register after `SYNC_STAGES` (default 2) clock edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| scan_en | input | 1 | Scan pulse; state advances only on edges where it is 1 |
| first_scan | input | 1 | Synchronous clear of the run state |
| start_req | input | 1 | Momentary start request, active high |
| estop_ok | input | 1 | Emergency-stop permissive, 1 = healthy |
| ovld_ok | input | 1 | Thermal-overload permissive, 1 = healthy |
| door_ok | input | 1 | Guard-door permissive, 1 = closed |
| run | output | 1 | Registered motor run command |
| permit_ok | output | 1 | AND of the three permissives |

## Verification
The assertions assume that inputs change away from the rising clock edge. They also assume that nothing is checked across the edge on which the internal reset releases. The bench drives every input on the falling edge and holds `scan_en` and `first_scan` low for several cycles after reset release, so the race-free window is respected. Random stimulus keeps the permissives mostly healthy, with occasional trips, so that seal, trip and recovery sequences all occur. Directed cases cover start-with-trip on one scan, recovery without restart, and first scan over a held start.

// File: rtl/motor_ilk_pkg.sv
package motor_ilk_pkg;
  localparam int unsigned NUM_PERMITS = 3;
  localparam int unsigned PERMIT_W    = NUM_PERMITS;

  typedef logic [PERMIT_W-1:0] permit_vec_t;

  typedef struct packed {
    logic scan_en;
    logic first_scan;
    logic start_req;
    logic permit;
  } scan_in_t;
endpackage

// File: rtl/motor_ilk_rst_sync.sv
module motor_ilk_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  localparam int unsigned LAST = STAGES - 1;

  logic [LAST:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= {chain_q[LAST:0], 1'b1} >> 0;
    end
  end

  assign rst_sync_n = chain_q[LAST];
endmodule

// File: rtl/motor_ilk_permit_chain.sv
module motor_ilk_permit_chain
  import motor_ilk_pkg::*;
(
  input  permit_vec_t permits,
  output logic        all_ok
);
  logic [PERMIT_W:0] chain;

  assign chain[0] = 1'b1;

  for (genvar g = 0; g < PERMIT_W; g++) begin : g_series
    assign chain[g+1] = chain[g] & permits[g];
  end

  assign all_ok = chain[PERMIT_W];
endmodule

// File: rtl/motor_ilk_latch_core.sv
module motor_ilk_latch_core
  import motor_ilk_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  scan_in_t scan_in,
  output logic     run
);
  logic run_q;
  logic run_d;
  logic sealed_req;

  assign sealed_req = scan_in.start_req | run_q;

  always_comb begin
    run_d = run_q;
    if (scan_in.first_scan) begin
      run_d = 1'b0;
    end else if (scan_in.scan_en) begin
      run_d = scan_in.permit & sealed_req;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
    end else begin
      run_q <= run_d;
    end
  end

  assign run = run_q;

  a_r2_trip_drops_run: assert property (@(posedge clk) disable iff (!rst_n)
    (scan_in.scan_en && !scan_in.permit) |=> !run_q);

  a_r3_start_sets_run: assert property (@(posedge clk) disable iff (!rst_n)
    (scan_in.scan_en && !scan_in.first_scan && scan_in.permit && scan_in.start_req) |=> run_q);

  a_r4_seal_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (scan_in.scan_en && !scan_in.first_scan && scan_in.permit && run_q) |=> run_q);

  a_r5_no_auto_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (!scan_in.start_req && !run_q) |=> !run_q);

  a_r7_hold_between_scans: assert property (@(posedge clk) disable iff (!rst_n)
    (!scan_in.scan_en && !scan_in.first_scan) |=> $stable(run_q));

  a_r8_first_scan_clears: assert property (@(posedge clk) disable iff (!rst_n)
    scan_in.first_scan |=> !run_q);
endmodule

// File: rtl/motor_run_ilk.sv
module motor_run_ilk
  import motor_ilk_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scan_en,
  input  logic first_scan,
  input  logic start_req,
  input  logic estop_ok,
  input  logic ovld_ok,
  input  logic door_ok,
  output logic run,
  output logic permit_ok
);
  logic        rst_sync_n;
  permit_vec_t permits;
  logic        all_ok;
  scan_in_t    scan_in;

  assign permits = {door_ok, ovld_ok, estop_ok};

  motor_ilk_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  motor_ilk_permit_chain u_permit (
    .permits (permits),
    .all_ok  (all_ok)
  );

  assign scan_in = '{scan_en: scan_en, first_scan: first_scan,
                     start_req: start_req, permit: all_ok};

  motor_ilk_latch_core u_core (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .scan_in (scan_in),
    .run     (run)
  );

  assign permit_ok = all_ok;

  a_r9_reset_clears: assert property (@(posedge clk) !rst_n |-> !run);

  a_r6_stop_dominates: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (scan_en && start_req && !(estop_ok && ovld_ok && door_ok)) |=> !run);
endmodule

// File: tb/motor_run_ilk_bench.sv
module motor_run_ilk_bench;
  logic clk = 1'b0;
  logic rst_n, scan_en, first_scan, start_req, estop_ok, ovld_ok, door_ok;
  logic run, permit_ok;
  logic exp_run;
  int   checks = 0;
  int   errors = 0;
  bit   done = 0;

  always #5 clk = ~clk;

  motor_run_ilk u_motor_run_ilk (
    .clk(clk), .rst_n(rst_n), .scan_en(scan_en), .first_scan(first_scan),
    .start_req(start_req), .estop_ok(estop_ok), .ovld_ok(ovld_ok),
    .door_ok(door_ok), .run(run), .permit_ok(permit_ok)
  );

  function automatic logic model_next(logic prev, logic sc, logic fs,
                                      logic st, logic e, logic o, logic d);
    if (fs) return 1'b0;
    if (!sc) return prev;
    return (e & o & d) & (st | prev);
  endfunction

  task automatic check(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(string req, logic sc, logic fs, logic st,
                      logic e, logic o, logic d);
    @(negedge clk);
    scan_en = sc; first_scan = fs; start_req = st;
    estop_ok = e; ovld_ok = o; door_ok = d;
    #1 check("R1", permit_ok, e & o & d);
    exp_run = model_next(exp_run, sc, fs, st, e, o, d);
    @(posedge clk);
    #1 check(req, run, exp_run);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 0; scan_en = 0; first_scan = 0; start_req = 0;
    estop_ok = 1; ovld_ok = 1; door_ok = 1;
    exp_run = 0;
    #2 check("R9", run, 1'b0);
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    check("R9", run, 1'b0);

    // R3 start, R4 seal
    step("R3", 1, 0, 1, 1, 1, 1);
    step("R4", 1, 0, 0, 1, 1, 1);
    step("R4", 1, 0, 0, 1, 1, 1);
    // R7 hold with trip but no scan
    step("R7", 0, 0, 0, 0, 1, 1);
    // R2 trip on each permissive
    step("R2", 1, 0, 0, 1, 1, 0);
    // R5 recovery does not restart
    step("R5", 1, 0, 0, 1, 1, 1);
    step("R5", 1, 0, 0, 1, 1, 1);
    step("R3", 1, 0, 1, 1, 1, 1);
    step("R2", 1, 0, 1, 1, 0, 1);
    step("R3", 1, 0, 1, 1, 1, 1);
    step("R2", 1, 0, 0, 0, 1, 1);
    // R6 start with trip same scan
    step("R6", 1, 0, 1, 0, 1, 1);
    step("R6", 1, 0, 1, 1, 0, 0);
    // R7 start without scan
    step("R7", 0, 0, 1, 1, 1, 1);
    step("R3", 1, 0, 1, 1, 1, 1);
    // R8 first scan overrides, even without scan_en
    step("R8", 1, 1, 1, 1, 1, 1);
    step("R3", 1, 0, 1, 1, 1, 1);
    step("R8", 0, 1, 0, 1, 1, 1);
    step("R5", 1, 0, 0, 1, 1, 1);

    // random mix
    for (int i = 0; i < 400; i++) begin
      logic sc, fs, st, e, o, d;
      sc = ($urandom % 4) != 0;
      fs = ($urandom % 20) == 0;
      st = ($urandom % 3) == 0;
      e  = ($urandom % 8) != 0;
      o  = ($urandom % 8) != 0;
      d  = ($urandom % 8) != 0;
      step("R2/R3/R4/R5/R7 random", sc, fs, st, e, o, d);
    end

    // R9 asynchronous reset mid-run
    step("R3", 1, 0, 1, 1, 1, 1);
    @(negedge clk);
    scan_en = 0; start_req = 0;
    #2 rst_n = 0;
    #1 check("R9", run, 1'b0);
    exp_run = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    check("R9", run, 1'b0);
    step("R5", 1, 0, 0, 1, 1, 1);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
  end
endmodule